// File: doc/BRIEF.md
# Deduplicating Tweak Cache

This block is a compact side store that keeps each distinct encryption tweak exactly once. The tweak is 134 bits wide, and its lowest six bits are an offset inside a page. A main cache line does not hold the whole tweak. It holds a short index into this store together with the low offset bits. The store holds the rest of the tweak, which is the high offset and all the non-offset fields. This reduces metadata storage per line from a full tweak to a few bits.

On a lookup, the high part of the tweak is folded into a set number. Both ways of that set are compared in parallel, and the index is returned one cycle later.
- If there is no match, an entry is allocated. An empty way is used if one exists.
- Otherwise the pseudo-LRU way of the set is replaced. If that victim still held a tweak, main-cache lines may depend on its index. The block therefore raises a flush request carrying that index and holds it until an acknowledge arrives. Lookups stall in the meantime.

A separate reverse port takes an index and a low offset and returns the full tweak one cycle later, for use at write-back time.

Top module: `tweak_dedup_cache`

## Requirements
- R1: After reset every entry is invalid, `lk_ready` is 1, and `flush_req` and `resp_valid` are 0.
- R2: An accepted lookup (`lk_req` high while `lk_ready` is high) whose high part is not stored, and whose target way is empty, is answered one cycle after acceptance. The answer is `resp_valid`=1 and `resp_hit`=0, and the tweak is written into the store.
- R3: A lookup whose bits [133:6] equal a stored entry is answered one cycle later with `resp_hit`=1 and that entry's index, whatever bits [5:0] are. A set never holds the same high part twice.
- R4: The set is the XOR of the 32 four-bit chunks of tweak bits [133:6]. The index is {set, way}, so the set occupies index bits [4:1] and the way occupies bit 0.
- R5: When a set has an empty way, allocation uses it, and way 0 is taken before way 1.
- R6: When both ways are valid, the least recently used way is the victim. Both hits and allocations count as uses.
- R7: Evicting a valid entry raises `flush_req` with `flush_idx` equal to the evicted index. Both are held until `flush_ack`. While they are held, `lk_ready` is 0 and no response is produced.
- R8: In the cycle after `flush_req` and `flush_ack` are both high at a clock edge, the response for the stalled lookup appears with `resp_hit`=0 and the evicted index. At the same time `flush_req` falls, and the entry now holds the new tweak.
- R9: A reverse request for a valid index returns, one cycle later, `rv_valid`=1, `rv_err`=0 and `rv_tweak` = {stored bits [133:6], `rv_low`}.
- R10: A reverse request for an invalid index returns `rv_valid`=1 and `rv_err`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_tweak | input | 134 | Tweak to look up, low offset in bits [5:0] |
| lk_ready | output | 1 | Lookup can be accepted |
| resp_valid | output | 1 | Lookup answer valid |
| resp_hit | output | 1 | Answer was a hit |
| resp_idx | output | 5 | Entry index {set, way} |
| flush_req | output | 1 | Flush of dependent main-cache lines requested |
| flush_idx | output | 5 | Index whose dependent lines must be flushed |
| flush_ack | input | 1 | Flush done |
| rv_req | input | 1 | Reverse lookup request |
| rv_idx | input | 5 | Index to expand |
| rv_low | input | 6 | Low offset from the main-cache line |
| rv_valid | output | 1 | Reverse answer valid |
| rv_err | output | 1 | Requested index was invalid |
| rv_tweak | output | 134 | Rebuilt full tweak |

## Verification
The assertions check three properties on every cycle:
- A pending flush keeps its index stable and blocks responses until it is acknowledged.
- Every response traces back to an accepted lookup or to an acknowledged flush.
- No set ever holds two valid copies of the same high part.

Only the bench scenarios can show the rest. These are the exact hash-to-index mapping, the order of empty-way filling, recency after a hit changing which entry is evicted, and the rebuilt tweaks and error flags on the reverse port.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int TC_TWEAK_W = 134;
  localparam int TC_LOW_W   = 6;
  localparam int TC_ENTRIES = 32;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FLUSH = 1'b1
  } tc_state_e;
endpackage

// File: rtl/tc_hash.sv
module tc_hash #(
  parameter int KEY_W = 128,
  parameter int SET_W = 4
) (
  input  logic [KEY_W-1:0] key_i,
  output logic [SET_W-1:0] set_o
);
  localparam int CHUNKS = (KEY_W + SET_W - 1) / SET_W;

  logic [CHUNKS*SET_W-1:0] padded;

  always_comb begin
    padded = '0;
    padded[KEY_W-1:0] = key_i;
    set_o = '0;
    for (int c = 0; c < CHUNKS; c++) begin
      set_o = set_o ^ padded[c*SET_W +: SET_W];
    end
  end
endmodule

// File: rtl/tc_victim.sv
module tc_victim (
  input  logic [1:0] valid_i,
  input  logic       lru_i,
  output logic       way_o,
  output logic       busy_o
);
  always_comb begin
    if (!valid_i[0]) begin
      way_o = 1'b0;
    end else if (!valid_i[1]) begin
      way_o = 1'b1;
    end else begin
      way_o = lru_i;
    end
    busy_o = valid_i[way_o];
  end
endmodule

// File: rtl/tweak_dedup_cache.sv
module tweak_dedup_cache
  import tc_pkg::*;
#(
  parameter int TWEAK_W = TC_TWEAK_W,
  parameter int LOW_W   = TC_LOW_W,
  parameter int ENTRIES = TC_ENTRIES,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_req,
  input  logic [TWEAK_W-1:0] lk_tweak,
  output logic               lk_ready,
  output logic               resp_valid,
  output logic               resp_hit,
  output logic [IDX_W-1:0]   resp_idx,
  output logic               flush_req,
  output logic [IDX_W-1:0]   flush_idx,
  input  logic               flush_ack,
  input  logic               rv_req,
  input  logic [IDX_W-1:0]   rv_idx,
  input  logic [LOW_W-1:0]   rv_low,
  output logic               rv_valid,
  output logic               rv_err,
  output logic [TWEAK_W-1:0] rv_tweak
);
  localparam int WAYS  = 2;
  localparam int SETS  = ENTRIES / WAYS;
  localparam int SET_W = $clog2(SETS);
  localparam int KEY_W = TWEAK_W - LOW_W;

  // storage
  logic [KEY_W-1:0]   key_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q, valid_nxt;
  logic [SETS-1:0]    lru_q, lru_nxt;   // bit = way to evict next

  tc_state_e state_q, state_nxt;
  logic [KEY_W-1:0] pend_key_q, pend_key_nxt;
  logic [SET_W-1:0] pend_set_q, pend_set_nxt;
  logic             pend_way_q, pend_way_nxt;

  logic             resp_valid_q, resp_valid_nxt;
  logic             resp_hit_q, resp_hit_nxt;
  logic [IDX_W-1:0] resp_idx_q, resp_idx_nxt;

  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [KEY_W-1:0] wr_key;

  logic               rv_valid_q, rv_err_q;
  logic [TWEAK_W-1:0] rv_tweak_q;

  // lookup datapath
  logic [KEY_W-1:0] in_key;
  logic [SET_W-1:0] in_set;
  logic [WAYS-1:0]  cand_valid, hit_w;
  logic             vic_way, vic_busy;

  assign in_key = lk_tweak[TWEAK_W-1:LOW_W];

  tc_hash #(.KEY_W(KEY_W), .SET_W(SET_W)) u_hash (
    .key_i (in_key),
    .set_o (in_set)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign cand_valid[w] = valid_q[{in_set, 1'(w)}];
    assign hit_w[w]      = cand_valid[w] && (key_q[{in_set, 1'(w)}] == in_key);
  end

  tc_victim u_victim (
    .valid_i (cand_valid),
    .lru_i   (lru_q[in_set]),
    .way_o   (vic_way),
    .busy_o  (vic_busy)
  );

  assign lk_ready  = (state_q == ST_IDLE);
  assign flush_req = (state_q == ST_FLUSH);
  assign flush_idx = {pend_set_q, pend_way_q};

  // next state
  always_comb begin
    state_nxt      = state_q;
    valid_nxt      = valid_q;
    lru_nxt        = lru_q;
    pend_key_nxt   = pend_key_q;
    pend_set_nxt   = pend_set_q;
    pend_way_nxt   = pend_way_q;
    resp_valid_nxt = 1'b0;
    resp_hit_nxt   = 1'b0;
    resp_idx_nxt   = resp_idx_q;
    wr_en          = 1'b0;
    wr_idx         = '0;
    wr_key         = '0;
    case (state_q)
      ST_IDLE: begin
        if (lk_req) begin
          if (|hit_w) begin
            resp_valid_nxt  = 1'b1;
            resp_hit_nxt    = 1'b1;
            resp_idx_nxt    = {in_set, hit_w[1]};
            lru_nxt[in_set] = ~hit_w[1];
          end else if (vic_busy) begin
            state_nxt    = ST_FLUSH;
            pend_key_nxt = in_key;
            pend_set_nxt = in_set;
            pend_way_nxt = vic_way;
          end else begin
            wr_en           = 1'b1;
            wr_idx          = {in_set, vic_way};
            wr_key          = in_key;
            resp_valid_nxt  = 1'b1;
            resp_idx_nxt    = {in_set, vic_way};
            lru_nxt[in_set] = ~vic_way;
          end
        end
      end
      ST_FLUSH: begin
        if (flush_ack) begin
          state_nxt           = ST_IDLE;
          wr_en               = 1'b1;
          wr_idx              = {pend_set_q, pend_way_q};
          wr_key              = pend_key_q;
          resp_valid_nxt      = 1'b1;
          resp_idx_nxt        = {pend_set_q, pend_way_q};
          lru_nxt[pend_set_q] = ~pend_way_q;
        end
      end
      default: state_nxt = ST_IDLE;
    endcase
    if (wr_en) valid_nxt[wr_idx] = 1'b1;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      valid_q      <= '0;
      lru_q        <= '0;
      resp_valid_q <= 1'b0;
      resp_hit_q   <= 1'b0;
      resp_idx_q   <= '0;
      rv_valid_q   <= 1'b0;
      rv_err_q     <= 1'b0;
    end else begin
      state_q      <= state_nxt;
      valid_q      <= valid_nxt;
      lru_q        <= lru_nxt;
      resp_valid_q <= resp_valid_nxt;
      resp_hit_q   <= resp_hit_nxt;
      resp_idx_q   <= resp_idx_nxt;
      rv_valid_q   <= rv_req;
      rv_err_q     <= rv_req && !valid_q[rv_idx];
    end
  end

  // data registers, no reset
  always_ff @(posedge clk) begin
    if (wr_en) key_q[wr_idx] <= wr_key;
    if (state_q == ST_IDLE && lk_req && !(|hit_w) && vic_busy) begin
      pend_key_q <= pend_key_nxt;
      pend_set_q <= pend_set_nxt;
      pend_way_q <= pend_way_nxt;
    end
    if (rv_req) rv_tweak_q <= {key_q[rv_idx], rv_low};
  end

  assign resp_valid = resp_valid_q;
  assign resp_hit   = resp_hit_q;
  assign resp_idx   = resp_idx_q;
  assign rv_valid   = rv_valid_q;
  assign rv_err     = rv_err_q;
  assign rv_tweak   = rv_tweak_q;

  // checks
  assert_flush_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req && !flush_ack |=> flush_req && $stable(flush_idx));

  assert_flush_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req && !flush_ack |=> !resp_valid);

  assert_resp_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(lk_req && lk_ready) || $past(flush_req && flush_ack));

  for (genvar s = 0; s < SETS; s++) begin : g_dup_chk
    assert_no_dup_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid_q[2*s] && valid_q[2*s+1] && key_q[2*s] == key_q[2*s+1]));
  end
endmodule

// File: tb/tweak_dedup_cache_bench.sv
module tweak_dedup_cache_bench;
  localparam int TW = 134;
  localparam int LW = 6;
  localparam int KW = TW - LW;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          lk_req, flush_ack, rv_req;
  logic [TW-1:0] lk_tweak;
  logic [IW-1:0] rv_idx;
  logic [LW-1:0] rv_low;
  logic          lk_ready, resp_valid, resp_hit, flush_req, rv_valid, rv_err;
  logic [IW-1:0] resp_idx, flush_idx;
  logic [TW-1:0] rv_tweak;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  tweak_dedup_cache u_tweak_dedup_cache (
    .clk, .rst_n, .lk_req, .lk_tweak, .lk_ready, .resp_valid, .resp_hit,
    .resp_idx, .flush_req, .flush_idx, .flush_ack, .rv_req, .rv_idx,
    .rv_low, .rv_valid, .rv_err, .rv_tweak
  );

  task automatic chk(input string tag, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] fold(input logic [KW-1:0] k);
    logic [3:0] h = '0;
    for (int i = 0; i < KW / 4; i++) h ^= k[i*4 +: 4];
    return h;
  endfunction

  // key landing in set s, distinguished by k
  function automatic logic [KW-1:0] mk(input logic [3:0] s, input logic [31:0] k);
    logic [KW-1:0] key = {96'h0, k} << 4;
    key[3:0] = s ^ fold(key);
    return key;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; lk_req = 1'b0; flush_ack = 1'b0; rv_req = 1'b0;
    lk_tweak = '0; rv_idx = '0; rv_low = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_lookup(input string tag, input logic [KW-1:0] key, input logic [LW-1:0] low,
                           input logic exp_hit, input logic [IW-1:0] exp_idx);
    @(negedge clk);
    lk_req = 1'b1; lk_tweak = {key, low};
    @(negedge clk);
    lk_req = 1'b0;
    chk({tag, " valid"}, TW'(resp_valid), TW'(1));
    chk({tag, " hit"},   TW'(resp_hit), TW'(exp_hit));
    chk({tag, " idx"},   TW'(resp_idx), TW'(exp_idx));
  endtask

  task automatic do_evict(input string tag, input logic [KW-1:0] key, input logic [IW-1:0] exp_idx);
    @(negedge clk);
    lk_req = 1'b1; lk_tweak = {key, 6'h11};
    @(negedge clk);
    lk_req = 1'b0;
    chk({tag, " R7 flush_req"}, TW'(flush_req), TW'(1));
    chk({tag, " R7 flush_idx"}, TW'(flush_idx), TW'(exp_idx));
    chk({tag, " R7 ready low"}, TW'(lk_ready), TW'(0));
    repeat (3) @(negedge clk);
    chk({tag, " R7 held"},      TW'(flush_req), TW'(1));
    chk({tag, " R7 idx held"},  TW'(flush_idx), TW'(exp_idx));
    chk({tag, " R7 no resp"},   TW'(resp_valid), TW'(0));
    flush_ack = 1'b1;
    @(negedge clk);
    flush_ack = 1'b0;
    chk({tag, " R8 resp"},      TW'(resp_valid), TW'(1));
    chk({tag, " R8 miss"},      TW'(resp_hit), TW'(0));
    chk({tag, " R8 idx"},       TW'(resp_idx), TW'(exp_idx));
    chk({tag, " R8 flush off"}, TW'(flush_req), TW'(0));
    chk({tag, " R8 ready"},     TW'(lk_ready), TW'(1));
  endtask

  task automatic do_rev(input string tag, input logic [IW-1:0] idx, input logic [LW-1:0] low,
                        input logic exp_err, input logic [TW-1:0] exp_tw);
    @(negedge clk);
    rv_req = 1'b1; rv_idx = idx; rv_low = low;
    @(negedge clk);
    rv_req = 1'b0;
    chk({tag, " rv_valid"}, TW'(rv_valid), TW'(1));
    chk({tag, " rv_err"},   TW'(rv_err), TW'(exp_err));
    if (!exp_err) chk({tag, " rv_tweak"}, rv_tweak, exp_tw);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 lk_ready", TW'(lk_ready), TW'(1));
    chk("R1 flush_req", TW'(flush_req), TW'(0));
    chk("R1 resp_valid", TW'(resp_valid), TW'(0));
    do_rev("R1 R10 empty idx0", 5'd0, 6'h0, 1'b1, '0);
  endtask

  task automatic t_fill_and_hit();
    do_lookup("R2 R5 first A", mk(4'd5, 1), 6'h00, 1'b0, 5'd10);
    do_lookup("R2 R5 second B", mk(4'd5, 2), 6'h01, 1'b0, 5'd11);
    do_lookup("R3 A other low", mk(4'd5, 1), 6'h3F, 1'b1, 5'd10);
    do_rev("R9 expand B", 5'd11, 6'h2A, 1'b0, {mk(4'd5, 2), 6'h2A});
    do_rev("R10 invalid idx3", 5'd3, 6'h00, 1'b1, '0);
  endtask

  task automatic t_evict();
    // A was used last, so B (way 1) is the LRU victim
    do_evict("R6 C evicts B", mk(4'd5, 3), 5'd11);
    do_evict("R6 B evicts A", mk(4'd5, 2), 5'd10);
    do_lookup("R8 C stored", mk(4'd5, 3), 6'h05, 1'b1, 5'd11);
    do_rev("R8 R9 idx10 holds B", 5'd10, 6'h07, 1'b0, {mk(4'd5, 2), 6'h07});
  endtask

  task automatic t_hash();
    logic [KW-1:0] k1, k2;
    logic [3:0] h1, h2;
    do_reset();
    do_rev("R1 old entry gone", 5'd10, 6'h0, 1'b1, '0);
    k1 = 128'h0123456789abcdef_fedcba9876543211;
    k2 = 128'hdeadbeef_cafef00d_13572468_9bdf0ace;
    h1 = fold(k1);
    h2 = fold(k2);
    do_lookup("R4 hash k1", k1, 6'h0, 1'b0, {h1, 1'b0});
    do_lookup("R4 hash k2", k2, 6'h0, 1'b0, (h2 == h1) ? {h1, 1'b1} : {h2, 1'b0});
    do_lookup("R3 R4 k1 hit", k1, 6'h22, 1'b1, {h1, 1'b0});
  endtask

  initial begin
    t_reset();
    t_fill_and_hit();
    t_evict();
    t_hash();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule